// File: doc/BRIEF.md
# Prescaled Auto-Reload Up-Counter Timebase

This block is the time base of a general-purpose timer. A count-enable tick is chosen from one of two sources: the timer clock itself, or single-cycle pulses made from the rising edges of an external input that is already filtered and synchronized. The tick feeds a 16-bit prescaler. The prescaler wraps at the value held in an active (shadow) register, so it divides by that value plus one. Each prescaler wrap advances a 16-bit up-counter. The up-counter runs from zero to an auto-reload limit, wraps back to zero and raises a one-cycle update event.

Software sets up the block through a small register-style write port. The port carries a control word, the prescaler preload, the reload limit and a self-clearing software update request. A new prescaler value written while the timer runs waits in the preload register. It reaches the active register only at the next update event, so the current period always finishes with the old divider. An update requested by software clears both counters at once and loads the preload register.

Top module: `tmb_timebase`

## Requirements
- R1: After reset the counter, the prescaler counter and the update output are all 0. The active prescale value is 0 and the reload limit is all ones.
- R2: A write is sampled at a rising clock edge. Address 0 is the control word: bit 0 is run, bit 1 is direction, bit 2 is the external-clock enable, bits 5:3 are slave mode and bits 8:6 are trigger select. Address 1 is the prescaler preload, address 2 is the reload limit, and address 3 bit 0 requests a software update. The counting decision at an edge uses the register contents from before that edge. The prescaler and the counter hold their values, and no update fires, unless run is 1 and direction is 0.
- R3: On each tick the prescaler counter steps from 0 up to the active prescale value and then wraps to 0. The main counter increments only on a tick where the prescaler wraps, so the division ratio is the active value plus one.
- R4: On each prescaler wrap the main counter steps from 0 up to the reload limit and then returns to 0. That return raises upd_o for exactly one cycle, and the cycle is the one in which cnt_o and psc_cnt_o first read 0.
- R5: With a reload limit of 0 the counter stays at 0 and upd_o pulses on every prescaler wrap. With a preload of 0 as well, upd_o pulses on every tick.
- R6: A preload written mid-period does not change the running division. It is copied into the active value only on the next update event.
- R7: Writing 1 to bit 0 at address 3 produces one update event one clock after the write is sampled, whether or not run is set. That event clears both counters, pulses upd_o once and loads the preload into the active value. The request clears itself.
- R8: When the external-clock enable bit is 1, each 0-to-1 change of ext_i (compared with its value at the previous clock edge) gives exactly one tick, however long the input stays high.
- R9: External clocking is also selected when slave mode and trigger select are both 3'b111. Any other combination with bit 2 at 0 uses the timer clock, where every cycle is a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 2 | Register select (0 control, 1 preload, 2 reload, 3 event) |
| wr_data | input | DATA_W | Write data |
| ext_i | input | 1 | Filtered, synchronized external clock input |
| cnt_o | output | CNT_W | Main counter value |
| psc_cnt_o | output | PSC_W | Prescaler counter value |
| upd_o | output | 1 | One-cycle update event pulse |

## Verification
The bench writes a new preload in the middle of a period and expects the old period to finish before the new ratio appears. A design that loaded the preload at once would shorten or stretch the running period. With a reload of 0, and with both values at 0, upd_o must fire on every wrap or on every cycle. An off-by-one wrap compare would skip pulses or show a count of 1.

The external input is held high for several cycles, and a slave/trigger combination that is only one bit away from the select code is tried. A level-sensitive design would over-count the long pulse, and a loose decoder would switch to the external source. Software updates are issued both while stopped and while running; a design that missed the clear or the shadow load would continue from stale values.

// File: rtl/tmb_pkg.sv
package tmb_pkg;

    // Control word, run in bit 0 up to trigger select in bits 8:6
    typedef struct packed {
        logic [2:0] trig;
        logic [2:0] slave;
        logic       ext1;
        logic       dir;
        logic       run;
    } tmb_ctrl_t;

    localparam int CTRL_W = $bits(tmb_ctrl_t);
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PRE    = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_EVT    = 2'd3;

    // Code that selects the external source through the slave/trigger pair
    localparam logic [2:0] EXT_SEL_CODE = 3'b111;

endpackage

// File: rtl/tmb_regs.sv
module tmb_regs
    import tmb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PSC_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              evt,
    output tmb_ctrl_t         ctrl,
    output logic [PSC_W-1:0]  psc_act,
    output logic [CNT_W-1:0]  reload,
    output logic              ug
);

    typedef struct packed {
        tmb_ctrl_t        ctrl;
        logic [PSC_W-1:0] psc_pre;
        logic [PSC_W-1:0] psc_act;
        logic [CNT_W-1:0] reload;
        logic             ug;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  unused_data;

    assign unused_data = ^wr_data;

    always_comb begin
        regs_d    = regs_q;
        regs_d.ug = 1'b0;
        // shadow takes the preload only on an update event
        if (evt) begin
            regs_d.psc_act = regs_q.psc_pre;
        end
        if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL:   regs_d.ctrl    = tmb_ctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_PRE:    regs_d.psc_pre = wr_data[PSC_W-1:0];
                ADDR_RELOAD: regs_d.reload  = wr_data[CNT_W-1:0];
                default:     regs_d.ug      = wr_data[0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q         <= '0;
            regs_q.reload  <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ctrl    = regs_q.ctrl;
    assign psc_act = regs_q.psc_act;
    assign reload  = regs_q.reload;
    assign ug      = regs_q.ug;

endmodule

// File: rtl/tmb_tick.sv
module tmb_tick
    import tmb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tmb_ctrl_t ctrl,
    input  logic      ext_i,
    output logic      tick,
    output logic      ext_sel
);

    typedef struct packed {
        logic ext_prev;
    } tick_t;

    tick_t tick_d, tick_q;
    logic  rise;

    always_comb begin
        tick_d.ext_prev = ext_i;
        ext_sel = ctrl.ext1 |
                  ((ctrl.slave == EXT_SEL_CODE) && (ctrl.trig == EXT_SEL_CODE));
        rise    = ext_i & ~tick_q.ext_prev;
        tick    = ctrl.run & ~ctrl.dir & (ext_sel ? rise : 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_d;
        end
    end

endmodule

// File: rtl/tmb_count.sv
module tmb_count #(
    parameter int PSC_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ug,
    input  logic [PSC_W-1:0] psc_act,
    input  logic [CNT_W-1:0] reload,
    output logic [PSC_W-1:0] pcnt,
    output logic [CNT_W-1:0] cnt,
    output logic             evt,
    output logic             upd
);

    typedef struct packed {
        logic [PSC_W-1:0] pcnt;
        logic [CNT_W-1:0] cnt;
        logic             upd;
    } count_t;

    count_t cnt_d, cnt_q;
    logic   psc_wrap;
    logic   ovf;

    always_comb begin
        psc_wrap  = tick && (cnt_q.pcnt >= psc_act);
        ovf       = psc_wrap && (cnt_q.cnt >= reload);
        evt       = ovf | ug;
        cnt_d     = cnt_q;
        cnt_d.upd = evt;
        if (ug) begin
            cnt_d.pcnt = '0;
            cnt_d.cnt  = '0;
        end else if (tick) begin
            if (psc_wrap) begin
                cnt_d.pcnt = '0;
                cnt_d.cnt  = ovf ? '0 : cnt_q.cnt + 1'b1;
            end else begin
                cnt_d.pcnt = cnt_q.pcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pcnt = cnt_q.pcnt;
    assign cnt  = cnt_q.cnt;
    assign upd  = cnt_q.upd;

endmodule

// File: rtl/tmb_timebase.sv
module tmb_timebase
    import tmb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PSC_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [PSC_W-1:0]  psc_cnt_o,
    output logic              upd_o
);

    tmb_ctrl_t        ctrl_w;
    logic [PSC_W-1:0] psc_act_w;
    logic [CNT_W-1:0] reload_w;
    logic             ug_w;
    logic             evt_w;
    logic             tick_w;
    logic             ext_sel_w;

    tmb_regs #(
        .DATA_W (DATA_W),
        .PSC_W  (PSC_W),
        .CNT_W  (CNT_W)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .evt     (evt_w),
        .ctrl    (ctrl_w),
        .psc_act (psc_act_w),
        .reload  (reload_w),
        .ug      (ug_w)
    );

    tmb_tick i_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (ctrl_w),
        .ext_i   (ext_i),
        .tick    (tick_w),
        .ext_sel (ext_sel_w)
    );

    tmb_count #(
        .PSC_W (PSC_W),
        .CNT_W (CNT_W)
    ) i_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_w),
        .ug      (ug_w),
        .psc_act (psc_act_w),
        .reload  (reload_w),
        .pcnt    (psc_cnt_o),
        .cnt     (cnt_o),
        .evt     (evt_w),
        .upd     (upd_o)
    );

endmodule

// File: rtl/tmb_timebase_chk.sv
module tmb_timebase_chk #(
    parameter int PSC_W = 16,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_o,
    input logic [PSC_W-1:0] psc_cnt_o,
    input logic             upd_o,
    input logic             tick,
    input logic             ext_sel,
    input logic             ug,
    input logic [PSC_W-1:0] psc_act
);

    // R4: an update pulse is seen only with both counters at zero
    a_r4_upd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (cnt_o == '0) && (psc_cnt_o == '0));

    // R2: without a tick or a software request nothing moves
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ug) |=> ($stable(cnt_o) && $stable(psc_cnt_o) && !upd_o));

    // R3: the main counter only changes when the prescaler reads zero
    a_r3_cnt_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o != $past(cnt_o)) |-> (psc_cnt_o == '0));

    // R6: the prescaler counter never runs past the active divider
    a_r6_pcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        psc_cnt_o <= psc_act);

    // R7: a software request always yields an update pulse next cycle
    a_r7_ug_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ug |=> upd_o);

    // R8: an external tick never lasts two cycles
    a_r8_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel && tick) |=> !(ext_sel && tick));

endmodule

bind tmb_timebase tmb_timebase_chk #(
    .PSC_W (PSC_W),
    .CNT_W (CNT_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_o     (cnt_o),
    .psc_cnt_o (psc_cnt_o),
    .upd_o     (upd_o),
    .tick      (tick_w),
    .ext_sel   (ext_sel_w),
    .ug        (ug_w),
    .psc_act   (psc_act_w)
);

// File: tb/test_tmb_timebase.sv
module test_tmb_timebase;

    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ext_i = 1'b0;
    logic [15:0] cnt_o;
    logic [15:0] psc_cnt_o;
    logic        upd_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [15:0] cnt;
        logic [15:0] pcnt;
        logic        upd;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    // bench model of the requirements
    longint   m_n = 0, m_p = 0, m_pend = 0, m_a = 16'hFFFF;
    bit [8:0] m_ctrl = '0;
    bit       m_prev = 0, m_ug = 0;

    always #(PER/2) clk = ~clk;

    tmb_timebase i_tmb_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ext_i     (ext_i),
        .cnt_o     (cnt_o),
        .psc_cnt_o (psc_cnt_o),
        .upd_o     (upd_o)
    );

    task automatic drive(input bit wr, input logic [1:0] a, input logic [15:0] dat,
                         input bit ext, input string req, input bit chk);
        exp_t e;
        bit   sel, tk, up;
        @(negedge clk);
        wr_en = wr; wr_addr = a; wr_data = dat; ext_i = ext;
        sel = m_ctrl[2] || (m_ctrl[5:3] == 3'b111 && m_ctrl[8:6] == 3'b111);
        tk  = m_ctrl[0] && !m_ctrl[1] && (sel ? (ext && !m_prev) : 1'b1);
        up  = 0;
        if (m_ug) begin
            m_n = 0; m_p = m_pend; up = 1;
        end else if (tk) begin
            m_n++;
            if (m_n == (m_p + 1) * (m_a + 1)) begin
                m_n = 0; m_p = m_pend; up = 1;
            end
        end
        e.pcnt = 16'(m_n % (m_p + 1));
        e.cnt  = 16'((m_n / (m_p + 1)) % (m_a + 1));
        e.upd  = up;
        e.req  = req;
        if (chk) exp_q.push_back(e);
        m_ug = 0;
        if (wr) begin
            case (a)
                2'd0: m_ctrl = dat[8:0];
                2'd1: m_pend = dat;
                2'd2: m_a    = dat;
                default: m_ug = dat[0];
            endcase
        end
        m_prev = ext;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) drive(0, 2'd0, 16'd0, 1'b0, req, 1);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d, input string req, input bit chk);
        drive(1, a, d, 1'b0, req, chk);
    endtask

    // stop, load divider and limit, then software update (R7 checked)
    task automatic setup(input logic [15:0] p, input logic [15:0] r);
        wr(2'd0, 16'd0, "", 0);
        wr(2'd1, p, "", 0);
        wr(2'd2, r, "", 0);
        wr(2'd3, 16'd1, "", 0);
        idle(1, "R7 update while stopped");
    endtask

    task automatic ext_run(input logic [19:0] pat, input string req);
        for (int i = 0; i < 20; i++) drive(0, 2'd0, 16'd0, pat[i], req, 1);
    endtask

    // monitor: compare each expected item a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #(PER/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (cnt_o !== e.cnt || psc_cnt_o !== e.pcnt || upd_o !== e.upd) begin
                    fails++;
                    $display("FAIL %s: got cnt=%0d pcnt=%0d upd=%0b, expected cnt=%0d pcnt=%0d upd=%0b",
                             e.req, cnt_o, psc_cnt_o, upd_o, e.cnt, e.pcnt, e.upd);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(3, "R1 reset state");

        // internal clock, divide by 3, limit 3
        setup(16'd2, 16'd3);
        wr(2'd0, 16'd1, "R3", 1);
        idle(30, "R3 R4 prescale and wrap");

        // stop and direction holds
        wr(2'd0, 16'd0, "R2 stop", 1);
        idle(5, "R2 run cleared");
        wr(2'd0, 16'd3, "R2 dir", 1);
        idle(5, "R2 dir set");
        wr(2'd0, 16'd1, "R2 resume", 1);
        idle(4, "R2 resume");

        // shadow preload
        setup(16'd1, 16'd2);
        wr(2'd0, 16'd1, "R6", 1);
        idle(3, "R6 before write");
        wr(2'd1, 16'd3, "R6 mid-period write", 1);
        idle(30, "R6 shadow");

        // software update while running
        wr(2'd3, 16'd1, "R7 running", 1);
        idle(8, "R7 running update");

        // zero limit
        setup(16'd0, 16'd0);
        wr(2'd0, 16'd1, "R5", 1);
        idle(6, "R5 every cycle");
        setup(16'd2, 16'd0);
        wr(2'd0, 16'd1, "R5", 1);
        idle(9, "R5 every wrap");

        // external enable bit
        setup(16'd1, 16'd2);
        wr(2'd0, 16'h0005, "R8", 1);
        ext_run(20'b0110_1111_0001_0101_1100, "R8 edge clock");
        ext_run(20'b1111_1111_1000_0000_1010, "R8 long high");

        // slave/trigger selection
        setup(16'd0, 16'd3);
        wr(2'd0, 16'h01F9, "R9", 1);
        ext_run(20'b0011_1001_0110_1110_0010, "R9 code 7/7 external");
        setup(16'd0, 16'd3);
        wr(2'd0, 16'h00F9, "R9", 1);
        ext_run(20'b0011_1001_0110_1110_0010, "R9 code 7/3 internal");

        wr(2'd0, 16'd0, "R2", 1);
        repeat (3) @(posedge clk);
        #(PER/2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule